// File: doc/BRIEF.md
# Dual Page Buffer Flash Read Controller

This block sits between a bus and a slow non-volatile array core and answers 64-bit reads from two local page buffers of 32 bytes each. A 17-bit word address arrives with a request. Its top 14 bits, together with the current shadow-row select, form a key that is compared against both buffers. On a match the addressed doubleword comes back one cycle later and the core is not touched. On a mismatch the block asks the core for the whole 32-byte page through a request/valid handshake. It forwards only the addressed doubleword and normally keeps the page in one of the buffers, chosen least-recently-used.

A bypass input turns the miss path into a pure pass-through that leaves both buffers and the replacement state alone. Any change of the shadow-row select drops both buffers, so the next read always goes to the core. Bus writes are acknowledged but change nothing, because programming and erasing are outside this block.

Top module: `flash_page_reader`

## Requirements
- R1: While rst_ni is low, and after it is released, ready_o and core_req_o are low, both buffers are invalid, and the first read misses.
- R2: addr_i[16:3] is the page tag and is driven on core_addr_o for a miss. addr_i[2:1] selects doubleword k, which is core_page_i[64k+63:64k]. addr_i[0] has no effect on any result.
- R3: A read whose key (shadow select, tag) matches a valid buffer raises ready_o in the next cycle with the buffered doubleword, and core_req_o stays low.
- R4: A read that misses raises core_req_o in the next cycle and holds it until core_valid_i is seen. ready_o rises in the cycle after core_valid_i, with the addressed doubleword of core_page_i and core_req_o low again.
- R5: A page fetched on a miss fills an invalid buffer if one exists (buffer 0 first), otherwise the least recently used one. Every hit and every fill marks its buffer most recent.
- R6: When rand_mode_i is high with a read request, a miss returns data from the core but fills no buffer and leaves the replacement order unchanged.
- R7: Any change of shadow_sel_i invalidates both buffers. A read in the same cycle as the change, or later, misses. A page whose fetch sees such a change is not kept.
- R8: core_shadow_o carries the shadow select sampled with the missing request, and buffered pages match only reads with the same shadow select.
- R9: A request with we_i high raises ready_o in the next cycle with zero data, issues no core read and leaves the buffer contents and order unchanged.
- R10: Requests presented while a core fetch is outstanding are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus request strobe, one cycle |
| we_i | input | 1 | Request is a write |
| addr_i | input | 17 | Word address |
| shadow_sel_i | input | 1 | Shadow-row select |
| rand_mode_i | input | 1 | Bypass mode: a miss does not fill |
| ready_o | output | 1 | Response strobe |
| rd_data_o | output | 64 | Response data |
| core_req_o | output | 1 | Page read request to the core |
| core_addr_o | output | 14 | Page tag for the core |
| core_shadow_o | output | 1 | Shadow select for the core read |
| core_valid_i | input | 1 | Core page valid strobe |
| core_page_i | input | 256 | Page data from the core |

## Verification
The bench first sweeps six pages through all eight low address values, so each doubleword selection and the ignored lowest bit are tried against both the miss path and the hit path. Directed runs of three pages that compete for two buffers separate true least-recently-used victims from round-robin or fixed choices. Shadow toggles placed before, together with, and during a fetch separate the flush from the key comparison. A long pseudo-random mix of reads, writes, bypass reads, shadow toggles and late requests is then compared against an arithmetic model. The page data encodes tag, shadow select, fetch number and doubleword index, so a stale or wrongly placed buffer shows up in the returned value.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  localparam int unsigned ADDR_W     = 17;
  localparam int unsigned DATA_W     = 64;
  localparam int unsigned PAGE_BYTES = 32;
  localparam int unsigned IGN_LSB    = 1;
  localparam int unsigned NUM_BUF    = 2;  // LRU is a single bit: two buffers

  localparam int unsigned PAGE_W = PAGE_BYTES * 8;
  localparam int unsigned WORDS  = PAGE_W / DATA_W;
  localparam int unsigned SEL_W  = $clog2(WORDS);
  localparam int unsigned TAG_W  = ADDR_W - SEL_W - IGN_LSB;
  localparam int unsigned BIDX_W = $clog2(NUM_BUF);
  localparam int unsigned KEY_W  = TAG_W + 1;

  typedef logic [KEY_W-1:0]  key_t;   // {shadow, tag}
  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [DATA_W-1:0] dword_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RESP  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/flash_shadow_track.sv
module flash_shadow_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shadow_i,
  output logic toggle_o
);
  logic shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= 1'b0;
    else         shadow_q <= shadow_i;
  end

  assign toggle_o = shadow_i ^ shadow_q;
endmodule

// File: rtl/flash_dword_sel.sv
module flash_dword_sel
  import flash_rd_pkg::*;
(
  input  page_t            page_i,
  input  logic [SEL_W-1:0] sel_i,
  output dword_t           dw_o
);
  dword_t words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_slice
    assign words[g] = page_i[g*DATA_W +: DATA_W];
  end

  assign dw_o = words[sel_i];
endmodule

// File: rtl/flash_page_bank.sv
module flash_page_bank
  import flash_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  key_t              key_i,
  output logic              hit_o,
  output logic [BIDX_W-1:0] hit_idx_o,
  output page_t             hit_page_o,
  input  logic              touch_i,
  input  logic              fill_i,
  input  key_t              fill_key_i,
  input  page_t             fill_page_i
);
  logic [NUM_BUF-1:0] valid_q;
  logic [NUM_BUF-1:0] match;
  key_t               key_q  [NUM_BUF];
  page_t              page_q [NUM_BUF];
  logic [BIDX_W-1:0]  lru_q;
  logic [BIDX_W-1:0]  victim;

  always_comb begin
    victim = lru_q;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (!valid_q[i]) victim = BIDX_W'(i);
    end
  end

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    logic load;
    assign load     = fill_i && (victim == BIDX_W'(g));
    assign match[g] = valid_q[g] && (key_q[g] == key_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      valid_q[g] <= 1'b0;
      else if (flush_i) valid_q[g] <= 1'b0;
      else if (load)    valid_q[g] <= 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   key_q[g] <= '0;
      else if (load) key_q[g] <= fill_key_i;
    end

    always_ff @(posedge clk_i) begin
      if (load) page_q[g] <= fill_page_i;
    end
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (match[i]) hit_idx_o = BIDX_W'(i);
    end
  end

  assign hit_o      = |match;
  assign hit_page_o = page_q[hit_idx_o];

  // recency: the other buffer becomes the next victim
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lru_q <= '0;
    else if (touch_i) lru_q <= ~hit_idx_o;
    else if (fill_i)  lru_q <= ~victim;
  end
endmodule

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl
  import flash_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              shadow_i,
  input  logic              toggle_i,
  input  logic              rand_i,
  input  logic              hit_i,
  input  dword_t            hit_dw_i,
  input  dword_t            core_dw_i,
  input  logic              core_valid_i,
  output key_t              lookup_key_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [SEL_W-1:0]  fetch_sel_o,
  output logic              touch_o,
  output logic              fill_o,
  output key_t              fill_key_o,
  output logic              flush_o,
  output logic              ready_o,
  output dword_t            data_o,
  output logic              core_req_o
);
  rd_state_e        state_q, state_d;
  key_t             key_q;
  logic [SEL_W-1:0] sel_q;
  logic             rand_q;
  logic             stale_q;
  dword_t           data_q, data_d;
  logic             accept, hit_ok;
  logic             unused_lsb;

  assign unused_lsb   = ^addr_i[IGN_LSB-1:0];
  assign lookup_key_o = {shadow_i, addr_i[ADDR_W-1 -: TAG_W]};
  assign sel_o        = addr_i[IGN_LSB +: SEL_W];
  assign fetch_sel_o  = sel_q;

  assign accept  = req_i && (state_q != ST_FETCH);
  assign hit_ok  = hit_i && !toggle_i;
  assign touch_o = accept && !we_i && hit_ok;
  assign flush_o = toggle_i;
  assign fill_o  = (state_q == ST_FETCH) && core_valid_i &&
                   !rand_q && !stale_q && !toggle_i;
  assign fill_key_o = key_q;

  always_comb begin
    state_d = state_q;
    data_d  = data_q;
    unique case (state_q)
      ST_FETCH: begin
        if (core_valid_i) begin
          state_d = ST_RESP;
          data_d  = core_dw_i;
        end
      end
      default: begin
        state_d = ST_IDLE;
        if (accept) begin
          if (we_i) begin
            state_d = ST_RESP;
            data_d  = '0;
          end else if (hit_ok) begin
            state_d = ST_RESP;
            data_d  = hit_dw_i;
          end else begin
            state_d = ST_FETCH;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      data_q  <= data_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q   <= '0;
      sel_q   <= '0;
      rand_q  <= 1'b0;
      stale_q <= 1'b0;
    end else if (accept && !we_i && !hit_ok) begin
      key_q   <= lookup_key_o;
      sel_q   <= sel_o;
      rand_q  <= rand_i;
      stale_q <= 1'b0;
    end else if (state_q == ST_FETCH && toggle_i) begin
      stale_q <= 1'b1;
    end
  end

  assign ready_o    = (state_q == ST_RESP);
  assign data_o     = data_q;
  assign core_req_o = (state_q == ST_FETCH);
endmodule

// File: rtl/flash_page_reader.sv
module flash_page_reader
  import flash_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              shadow_sel_i,
  input  logic              rand_mode_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              core_req_o,
  output logic [TAG_W-1:0]  core_addr_o,
  output logic              core_shadow_o,
  input  logic              core_valid_i,
  input  logic [PAGE_W-1:0] core_page_i
);
  logic              toggle;
  key_t              lookup_key, fill_key;
  logic [SEL_W-1:0]  sel, fetch_sel;
  logic              hit, touch, fill, flush;
  logic [BIDX_W-1:0] hit_idx;
  page_t             hit_page;
  dword_t            hit_dw, core_dw;

  flash_shadow_track u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shadow_i (shadow_sel_i),
    .toggle_o (toggle)
  );

  flash_page_bank u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .key_i       (lookup_key),
    .hit_o       (hit),
    .hit_idx_o   (hit_idx),
    .hit_page_o  (hit_page),
    .touch_i     (touch),
    .fill_i      (fill),
    .fill_key_i  (fill_key),
    .fill_page_i (core_page_i)
  );

  flash_dword_sel u_hit_sel (
    .page_i (hit_page),
    .sel_i  (sel),
    .dw_o   (hit_dw)
  );

  flash_dword_sel u_core_sel (
    .page_i (core_page_i),
    .sel_i  (fetch_sel),
    .dw_o   (core_dw)
  );

  flash_rd_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .shadow_i     (shadow_sel_i),
    .toggle_i     (toggle),
    .rand_i       (rand_mode_i),
    .hit_i        (hit),
    .hit_dw_i     (hit_dw),
    .core_dw_i    (core_dw),
    .core_valid_i (core_valid_i),
    .lookup_key_o (lookup_key),
    .sel_o        (sel),
    .fetch_sel_o  (fetch_sel),
    .touch_o      (touch),
    .fill_o       (fill),
    .fill_key_o   (fill_key),
    .flush_o      (flush),
    .ready_o      (ready_o),
    .data_o       (rd_data_o),
    .core_req_o   (core_req_o)
  );

  assign core_addr_o   = fill_key[TAG_W-1:0];
  assign core_shadow_o = fill_key[TAG_W];
endmodule

// File: rtl/flash_page_reader_chk.sv
module flash_page_reader_chk
  import flash_rd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              shadow_sel_i,
  input logic              rand_mode_i,
  input logic              ready_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              core_req_o,
  input logic [TAG_W-1:0]  core_addr_o,
  input logic              core_shadow_o,
  input logic              core_valid_i,
  input logic [PAGE_W-1:0] core_page_i
);
  logic unused_chk;
  assign unused_chk = rand_mode_i ^ (^core_page_i);

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!ready_o && !core_req_o)); // R1

  AST_READ_HIT_OR_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !core_req_o) |=> (ready_o ^ core_req_o)); // R3

  AST_FETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_req_o && !core_valid_i) |=> (core_req_o && $stable(core_addr_o) && !ready_o)); // R4

  AST_FETCH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_req_o && core_valid_i) |=> (ready_o && !core_req_o)); // R4

  AST_FETCH_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_req_o) |-> (core_addr_o == $past(addr_i[ADDR_W-1 -: TAG_W]))); // R2

  AST_FETCH_SHADOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_req_o) |-> (core_shadow_o == $past(shadow_sel_i))); // R8

  AST_TOGGLE_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !core_req_o && (shadow_sel_i != $past(shadow_sel_i)))
      |=> core_req_o); // R7

  AST_WRITE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !core_req_o) |=> (ready_o && !core_req_o && rd_data_o == '0)); // R9

  AST_READY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ($past(req_i && !core_req_o) || $past(core_req_o && core_valid_i))); // R10
endmodule

bind flash_page_reader flash_page_reader_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .we_i          (we_i),
  .addr_i        (addr_i),
  .shadow_sel_i  (shadow_sel_i),
  .rand_mode_i   (rand_mode_i),
  .ready_o       (ready_o),
  .rd_data_o     (rd_data_o),
  .core_req_o    (core_req_o),
  .core_addr_o   (core_addr_o),
  .core_shadow_o (core_shadow_o),
  .core_valid_i  (core_valid_i),
  .core_page_i   (core_page_i)
);

// File: tb/flash_page_reader_tb.sv
module flash_page_reader_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_i = 1'b0;
  logic         we_i = 1'b0;
  logic [16:0]  addr_i = '0;
  logic         shadow_sel_i = 1'b0;
  logic         rand_mode_i = 1'b0;
  logic         ready_o;
  logic [63:0]  rd_data_o;
  logic         core_req_o;
  logic [13:0]  core_addr_o;
  logic         core_shadow_o;
  logic         core_valid_i = 1'b0;
  logic [255:0] core_page_i = '0;

  flash_page_reader u_dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .req_i (req_i), .we_i (we_i),
    .addr_i (addr_i), .shadow_sel_i (shadow_sel_i), .rand_mode_i (rand_mode_i),
    .ready_o (ready_o), .rd_data_o (rd_data_o), .core_req_o (core_req_o),
    .core_addr_o (core_addr_o), .core_shadow_o (core_shadow_o),
    .core_valid_i (core_valid_i), .core_page_i (core_page_i)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;

  // reference model
  bit        m_val [2];
  bit [14:0] m_key [2];
  int        m_gen [2];
  int        m_lru = 0;
  int        gen_cnt = 0;
  bit        cur_sh = 0;

  function automatic logic [63:0] pdw(input logic [13:0] t, input bit sh,
                                      input int g, input int k);
    logic [15:0] g16;
    logic [3:0]  k4;
    g16 = g[15:0];
    k4  = k[3:0];
    return {g16, k4, 3'b000, sh, 2'b00, t, 24'h5A3C96 ^ {10'd0, t}};
  endfunction

  function automatic logic [255:0] page(input logic [13:0] t, input bit sh, input int g);
    logic [255:0] p;
    for (int k = 0; k < 4; k++) p[k*64 +: 64] = pdw(t, sh, g, k);
    return p;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic set_sh(input bit v);
    if (v != cur_sh) begin
      m_val[0] = 0;
      m_val[1] = 0;
    end
    cur_sh = v;
    shadow_sel_i = v;
  endtask

  // starts and ends just after a falling edge
  task automatic rd(input logic [16:0] a, input bit rnd, input bit mid_tog, input bit mid_req);
    bit        hit = 0;
    int        hidx = 0;
    bit        stale = 0;
    bit        sh_req;
    int        lat;
    int        vic;
    logic [14:0] key;
    key    = {cur_sh, a[16:3]};
    sh_req = cur_sh;
    for (int i = 1; i >= 0; i--) if (m_val[i] && m_key[i] == key) begin hit = 1; hidx = i; end
    req_i = 1; we_i = 0; addr_i = a; rand_mode_i = rnd;
    @(negedge clk_i);
    req_i = 0; rand_mode_i = 0;
    if (hit) begin
      chk("R3 hit ready", 64'(ready_o), 64'd1);
      chk("R3 hit data", rd_data_o, pdw(a[16:3], sh_req, m_gen[hidx], int'(a[2:1])));
      chk("R3 no core read on hit", 64'(core_req_o), 64'd0);
      m_lru = 1 - hidx;
    end else begin
      chk("R4 miss core_req", 64'(core_req_o), 64'd1);
      chk("R4 miss ready low", 64'(ready_o), 64'd0);
      chk("R2 core tag", 64'(core_addr_o), 64'(a[16:3]));
      chk("R8 core shadow", 64'(core_shadow_o), 64'(sh_req));
      lat = 1 + (gen_cnt % 4);
      for (int i = 0; i < lat; i++) begin
        if (i == 0 && mid_req) begin req_i = 1; addr_i = a ^ 17'h1F8; end
        if (i == 0 && mid_tog) begin set_sh(!cur_sh); stale = 1; end
        @(negedge clk_i);
        req_i = 0;
        chk("R10 no response while fetching", 64'(ready_o), 64'd0);
        chk("R4 core_req held", 64'(core_req_o), 64'd1);
      end
      core_valid_i = 1;
      core_page_i  = page(a[16:3], sh_req, gen_cnt);
      @(negedge clk_i);
      core_valid_i = 0;
      chk("R4 miss ready", 64'(ready_o), 64'd1);
      chk("R4 miss data", rd_data_o, pdw(a[16:3], sh_req, gen_cnt, int'(a[2:1])));
      chk("R4 core_req released", 64'(core_req_o), 64'd0);
      if (!rnd && !stale) begin
        vic = !m_val[0] ? 0 : (!m_val[1] ? 1 : m_lru);
        m_val[vic] = 1; m_key[vic] = key; m_gen[vic] = gen_cnt;
        m_lru = 1 - vic;
      end
      gen_cnt++;
    end
  endtask

  task automatic wr(input logic [16:0] a);
    req_i = 1; we_i = 1; addr_i = a;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
    chk("R9 write ready", 64'(ready_o), 64'd1);
    chk("R9 write data zero", rd_data_o, 64'd0);
    chk("R9 write no core read", 64'(core_req_o), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    summary();
  end

  initial begin
    logic [15:0] lf;
    logic [13:0] tags [4];
    logic [13:0] ta, tb_, tc, td, te;
    ta = 14'h0123; tb_ = 14'h2A5C; tc = 14'h1F00; td = 14'h3FFF; te = 14'h0000;

    repeat (3) @(negedge clk_i);
    chk("R1 reset ready", 64'(ready_o), 64'd0);
    chk("R1 reset core_req", 64'(core_req_o), 64'd0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 idle after reset", 64'(ready_o | core_req_o), 64'd0);

    // R2/R3 sweep: every doubleword select and lsb on six pages
    for (int p = 0; p < 6; p++) begin
      logic [13:0] t;
      t = 14'((p * 32'h0A53 + 3) & 32'h3FFF);
      for (int w = 0; w < 8; w++) rd({t, 3'(w)}, 0, 0, 0);
      for (int w = 7; w >= 0; w--) rd({t, 3'(w)}, 0, 0, 0);
    end

    // R5 LRU ordering with three competing pages
    set_sh(1); @(negedge clk_i);
    set_sh(0); @(negedge clk_i);
    rd({ta, 3'd0}, 0, 0, 0);
    rd({tb_, 3'd2}, 0, 0, 0);
    rd({ta, 3'd4}, 0, 0, 0);
    rd({tc, 3'd6}, 0, 0, 0);
    rd({ta, 3'd1}, 0, 0, 0);
    rd({tb_, 3'd3}, 0, 0, 0);
    rd({tc, 3'd5}, 0, 0, 0);
    rd({tb_, 3'd7}, 0, 0, 0);

    // R6 bypass miss leaves buffers and order alone
    rd({td, 3'd2}, 1, 0, 0);
    rd({td, 3'd4}, 1, 0, 0);
    rd({tb_, 3'd0}, 0, 0, 0);
    rd({td, 3'd6}, 0, 0, 0);

    // R7/R8 shadow toggles
    set_sh(1); @(negedge clk_i);
    rd({td, 3'd6}, 0, 0, 0);
    rd({td, 3'd6}, 0, 0, 0);
    set_sh(0);
    rd({td, 3'd6}, 0, 0, 0);
    rd({te, 3'd2}, 0, 1, 0);
    rd({te, 3'd2}, 0, 0, 0);
    rd({te, 3'd2}, 0, 0, 0);

    // R10 request during fetch
    rd({ta, 3'd0}, 0, 0, 1);
    rd({ta ^ 14'h003F, 3'd0}, 0, 0, 0);

    // R9 writes change nothing
    wr({ta, 3'd0});
    wr({tc, 3'd4});
    rd({ta, 3'd2}, 0, 0, 0);

    // pseudo-random mix
    tags[0] = ta; tags[1] = tb_; tags[2] = tc; tags[3] = td;
    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      int op;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      op = int'(lf[7:4]);
      if (op == 0)      wr({tags[lf[1:0]], lf[10:8]});
      else if (op == 1) rd({tags[lf[1:0]], lf[10:8]}, 1, 0, 0);
      else if (op == 2) begin set_sh(!cur_sh); @(negedge clk_i); end
      else if (op == 3) rd({tags[lf[1:0]], lf[10:8]}, 0, lf[11], lf[12]);
      else if (op == 4) begin set_sh(!cur_sh); rd({tags[lf[1:0]], lf[10:8]}, 0, 0, 0); end
      else              rd({tags[lf[1:0]], lf[10:8]}, 0, 0, 0);
    end

    @(negedge clk_i);
    chk("R4 quiet at end", 64'(ready_o | core_req_o), 64'd0);
    summary();
  end
endmodule